// File: doc/BRIEF.md
# Triggered Three-Channel PWM Timer

This block is a 16-bit up-counter that drives three PWM outputs sharing one period. Nothing happens until a qualifying edge arrives on an external trigger pin. That edge clears the counter and starts a cycle, and any later qualifying edge restarts the cycle from zero. One compare value sets the period. Three more compare values set how long each output stays active at the start of every cycle.

A host programs the block through a small write/read register port. The register map, by address, is as follows:
- 0: control. Bit 0 is run; bits 2:1 select the trigger edge.
- 1: period.
- 2, 3, 4: widths for outputs 0, 1, 2.
- 5: the live counter, read-only.

Writes to the period and width registers land in staging copies. Writing the output-0 width register arms a group transfer. The staged set then becomes active at the next cycle boundary, which is either a counter wrap or a trigger start.

Top module: `trig_pwm3`

## Requirements
- R1: With active period value P, the counter steps 0,1,…,P on count-enabled cycles and then returns to 0, so one PWM cycle lasts P+1 count cycles.
- R2: Output k is active while the counter is below width value Wk. It is inactive for the whole cycle when Wk = 0 and active for the whole cycle when Wk > P.
- R3: Writes to the period (address 1) and to the widths of outputs 1 and 2 (addresses 3, 4) change nothing at the outputs until the output-0 width (address 2) is written. After that write, the whole staged set becomes active at the next wrap or trigger start, and the arm is then cleared.
- R4: Control bits 2:1 pick the qualifying trigger edge: 00 none, 01 rising, 10 falling, 11 both.
- R5: The trigger passes a two-flop synchronizer. A qualifying pin change made before clock edge k leaves the counter at 0 after edge k+2, including when a cycle is already in progress.
- R6: Until the first qualifying trigger, the counter stays at 0 and all outputs stay inactive.
- R7: Reading address 5 returns the live counter. Reading addresses 0 to 4 returns the control value and the staged compare values.
- R8: Clearing control bit 0 (run) returns the counter to 0 and makes all outputs inactive. A new trigger is then required to restart.
- R9: While the count enable is low, the counter holds its value.
- R10: After reset, all registers read 0, the counter is 0 and all outputs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| cnt_en | input | 1 | Count-clock enable, one count per high cycle |
| trig_in | input | 1 | Asynchronous external trigger pin |
| pwm_out | output | 3 | PWM outputs, active high |

## Verification
The assertions assume that trig_in may change at any time but holds each level for at least three clocks, so the synchronizer sees every change. They assume cnt_en is a clean synchronous enable. The counter-range check also relies on the period taking a new value only at a boundary, where the counter is zero. The stimulus drives every pin on the falling clock edge and spaces trigger changes by several clocks. It always waits past a full period after arming before it expects a new compare set.

// File: rtl/trig_pwm3_pkg.sv
package trig_pwm3_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam int CTRL_ADDR    = 0;
   localparam int PERIOD_ADDR  = 1;
   localparam int FIRST_W_ADDR = 2;
endpackage

// File: rtl/trig_pwm3_edge.sv
module trig_pwm3_edge
   import trig_pwm3_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  edge_sel_e sel,
   output logic      edge_o
);
   logic [SYNC_STAGES:0] sh;
   logic synced, prev, rise, fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], pin};
   end

   assign synced = sh[SYNC_STAGES-1];
   assign prev   = sh[SYNC_STAGES];
   assign rise   = synced & ~prev;
   assign fall   = ~synced & prev;

   always_comb begin
      unique case (sel)
         EDGE_RISE: edge_o = rise;
         EDGE_FALL: edge_o = fall;
         EDGE_BOTH: edge_o = rise | fall;
         default:   edge_o = 1'b0;
      endcase
   end

   // R4: the "none" selection never yields a trigger
   p_no_edge_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EDGE_NONE) |-> !edge_o);
   // R4: a trigger is reported only after the synchronized level has changed
   p_edge_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> $past(synced) != $past(prev));
endmodule

// File: rtl/trig_pwm3_regs.sv
module trig_pwm3_regs
   import trig_pwm3_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_OUT  = 3,
   parameter int ADDR_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [CNT_W-1:0]            wdata,
   input  logic                        load_req,
   input  logic [CNT_W-1:0]            cnt,
   output logic                        run,
   output edge_sel_e                   sel,
   output logic [CNT_W-1:0]            act_per,
   output logic [N_OUT-1:0][CNT_W-1:0] act_w,
   output logic [CNT_W-1:0]            rdata
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(PERIOD_ADDR);
   localparam logic [ADDR_W-1:0] A_W0   = ADDR_W'(FIRST_W_ADDR);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(FIRST_W_ADDR + N_OUT);

   logic [CNT_W-1:0]            stg_per;
   logic [N_OUT-1:0][CNT_W-1:0] stg_w;
   logic                        armed;
   logic                        arm_wr;

   assign arm_wr = we && (addr == A_W0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         sel     <= EDGE_NONE;
         stg_per <= '0;
         stg_w   <= '0;
      end else if (we) begin
         if (addr == A_CTRL) begin
            run <= wdata[0];
            sel <= edge_sel_e'(wdata[2:1]);
         end
         if (addr == A_PER) stg_per <= wdata;
         for (int k = 0; k < N_OUT; k++)
            if (addr == ADDR_W'(FIRST_W_ADDR + k)) stg_w[k] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         act_per <= '0;
         act_w   <= '0;
      end else begin
         if (load_req && armed) begin
            act_per <= stg_per;
            act_w   <= stg_w;
         end
         if (arm_wr)        armed <= 1'b1;
         else if (load_req) armed <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CTRL) rdata = CNT_W'({sel, run});
      if (addr == A_PER)  rdata = stg_per;
      for (int k = 0; k < N_OUT; k++)
         if (addr == ADDR_W'(FIRST_W_ADDR + k)) rdata = stg_w[k];
      if (addr == A_CNT)  rdata = cnt;
   end

   // R3: an unarmed block keeps its active compare set
   p_hold_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> $stable(act_per) && $stable(act_w));
   // R3: an armed boundary transfers the staged period and drops the arm
   p_arm_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && armed && !arm_wr) |=> !armed && act_per == $past(stg_per));
endmodule

// File: rtl/trig_pwm3_cnt.sv
module trig_pwm3_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             cnt_en,
   input  logic             trig_edge,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             load_req
);
   logic start, at_top, wrap;

   assign start    = run & trig_edge;
   assign at_top   = (cnt == period);
   assign wrap     = running & cnt_en & at_top & ~start;
   assign load_req = start | wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (!run) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (start) begin
         cnt     <= '0;
         running <= 1'b1;
      end else if (running && cnt_en) begin
         cnt <= at_top ? '0 : cnt + 1'b1;
      end
   end

   // R1: counter never passes the active period value
   p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= period);
   // R1: counting step below the top
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && running && cnt_en && !trig_edge && cnt < period) |=> cnt == $past(cnt) + 1'b1);
   // R1: wrap at the top
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && running && cnt_en && !trig_edge && cnt == period) |=> cnt == '0);
   // R5: a qualifying edge starts from zero
   p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && trig_edge) |=> running && cnt == '0);
   // R6: idle counter sits at zero
   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> cnt == '0);
   // R8: clearing run stops and clears
   p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !running && cnt == '0);
   // R9: count enable low holds the value
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !trig_edge && !cnt_en) |=> $stable(cnt));
endmodule

// File: rtl/trig_pwm3.sv
module trig_pwm3
   import trig_pwm3_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_OUT       = 3,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              cnt_en,
   input  logic              trig_in,
   output logic [N_OUT-1:0]  pwm_out
);
   localparam int N_REGS = FIRST_W_ADDR + N_OUT + 1;

   generate
      if (CNT_W < 3) begin : g_bad_width
         $error("CNT_W must be at least 3");
      end
      if (N_OUT < 1) begin : g_bad_nout
         $error("N_OUT must be at least 1");
      end
      if ((1 << ADDR_W) < N_REGS) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   edge_sel_e                   sel;
   logic                        run, trig_edge, running, load_req;
   logic [CNT_W-1:0]            cnt, act_per;
   logic [N_OUT-1:0][CNT_W-1:0] act_w;
   logic [N_OUT-1:0]            hit;

   trig_pwm3_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(trig_in), .sel(sel), .edge_o(trig_edge)
   );

   trig_pwm3_regs #(.CNT_W(CNT_W), .N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .load_req(load_req), .cnt(cnt), .run(run), .sel(sel),
      .act_per(act_per), .act_w(act_w), .rdata(reg_rdata)
   );

   trig_pwm3_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt_en(cnt_en), .trig_edge(trig_edge),
      .period(act_per), .cnt(cnt), .running(running), .load_req(load_req)
   );

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_cmp
         assign hit[k] = running & (cnt < act_w[k]);
         // R2: zero width never drives the output
         p_zero_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (act_w[k] == '0) |-> !hit[k]);
         // R2: width beyond the period keeps the output on while running
         p_full_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (running && act_w[k] > act_per) |-> hit[k]);
      end

      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_out <= '0;
            else        pwm_out <= hit;
         end
      end else begin : g_out_comb
         assign pwm_out = hit;
         // R6: nothing active while idle
         p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !running |-> pwm_out == '0);
      end
   endgenerate
endmodule

// File: tb/sim_trig_pwm3.sv
module sim_trig_pwm3;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd5;
   logic [15:0] reg_wdata = '0;
   logic        cnt_en = 1'b0;
   logic        trig_in = 1'b0;
   logic [15:0] reg_rdata;
   logic [2:0]  pwm_out;

   int checks = 0;
   int errors = 0;

   trig_pwm3 u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_en(cnt_en),
      .trig_in(trig_in), .pwm_out(pwm_out)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 3'd5;
   endtask

   task automatic rd_check(input logic [2:0] a, input logic [15:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1 check(reg_rdata == exp, req, reg_rdata, exp);
      reg_addr = 3'd5;
   endtask

   task automatic wait_zero();
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         #1;
         if (reg_rdata == 16'd0) break;
      end
   endtask

   // one full period: counter value and each output per cycle
   task automatic measure(input int p, input int w0, input int w1, input int w2, input string req);
      int w[3];
      w[0] = w0; w[1] = w1; w[2] = w2;
      wait_zero();
      for (int i = 0; i <= p; i++) begin
         if (i > 0) begin
            @(negedge clk);
            #1;
         end
         check(reg_rdata == 16'(i), {req, " R1 R7 counter"}, reg_rdata, i);
         for (int k = 0; k < 3; k++)
            check(pwm_out[k] == (i < w[k]), {req, " R2 output"}, pwm_out[k], (i < w[k]));
      end
      @(negedge clk);
      #1 check(reg_rdata == 16'd0, {req, " R1 wrap"}, reg_rdata, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      #1;
      check(pwm_out == 3'b000, "R10 outputs", pwm_out, 0);
      check(reg_rdata == 16'd0, "R10 counter", reg_rdata, 0);
      rd_check(3'd0, 16'd0, "R10 control");
      rd_check(3'd1, 16'd0, "R10 period");
      rd_check(3'd4, 16'd0, "R10 width");
   endtask

   task automatic t_idle();
      cnt_en = 1'b1;
      wr(3'd1, 16'd9);
      wr(3'd3, 16'd5);
      wr(3'd4, 16'd12);
      wr(3'd2, 16'd3);
      wr(3'd0, 16'b011);
      repeat (20) @(negedge clk);
      #1;
      check(pwm_out == 3'b000, "R6 outputs idle", pwm_out, 0);
      check(reg_rdata == 16'd0, "R6 counter idle", reg_rdata, 0);
      rd_check(3'd1, 16'd9, "R7 period readback");
      rd_check(3'd4, 16'd12, "R7 width readback");
      rd_check(3'd0, 16'd3, "R7 control readback");
   endtask

   task automatic t_rise();
      @(negedge clk);
      trig_in = 1'b1;
      repeat (3) @(negedge clk);
      #1 check(reg_rdata == 16'd0 && pwm_out[0], "R5 rising start", reg_rdata, 0);
      measure(9, 3, 5, 12, "rise");
   endtask

   task automatic t_stage();
      wr(3'd3, 16'd0);
      wr(3'd4, 16'd2);
      wr(3'd1, 16'd4);
      repeat (30) @(negedge clk);
      measure(9, 3, 5, 12, "R3 unarmed");
      wr(3'd2, 16'd9);
      repeat (12) @(negedge clk);
      measure(4, 9, 0, 2, "R3 armed");
   endtask

   task automatic t_enable();
      logic [15:0] held;
      wait_zero();
      @(negedge clk);
      @(negedge clk);
      cnt_en = 1'b0;
      @(negedge clk);
      #1 held = reg_rdata;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         #1 check(reg_rdata == held, "R9 hold", reg_rdata, held);
      end
      cnt_en = 1'b1;
   endtask

   task automatic t_restart();
      wr(3'd0, 16'b111);
      wr(3'd1, 16'd30);
      wr(3'd2, 16'd9);
      repeat (12) @(negedge clk);
      wait_zero();
      repeat (5) @(negedge clk);
      trig_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      #1 check(reg_rdata == 16'd7, "R5 before restart", reg_rdata, 7);
      @(negedge clk);
      #1 check(reg_rdata == 16'd0, "R5 R4 both-edge restart", reg_rdata, 0);
   endtask

   task automatic t_stop_fall();
      wr(3'd0, 16'b100);
      @(negedge clk);
      #1;
      check(reg_rdata == 16'd0, "R8 counter cleared", reg_rdata, 0);
      check(pwm_out == 3'b000, "R8 outputs off", pwm_out, 0);
      wr(3'd0, 16'b101);
      @(negedge clk);
      trig_in = 1'b1;
      repeat (6) @(negedge clk);
      #1;
      check(reg_rdata == 16'd0, "R4 rising ignored", reg_rdata, 0);
      check(pwm_out == 3'b000, "R4 rising ignored outputs", pwm_out, 0);
      trig_in = 1'b0;
      repeat (3) @(negedge clk);
      #1 check(pwm_out[0] == 1'b1 && reg_rdata == 16'd0, "R4 falling start", pwm_out, 1);
      @(negedge clk);
      #1 check(reg_rdata == 16'd1, "R4 falling counts", reg_rdata, 1);
   endtask

   task automatic t_none();
      wr(3'd0, 16'b000);
      wr(3'd0, 16'b001);
      @(negedge clk);
      trig_in = 1'b1;
      repeat (6) @(negedge clk);
      #1 check(reg_rdata == 16'd0 && pwm_out == 3'b000, "R4 none rising", reg_rdata, 0);
      trig_in = 1'b0;
      repeat (6) @(negedge clk);
      #1 check(reg_rdata == 16'd0 && pwm_out == 3'b000, "R4 none falling", reg_rdata, 0);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_idle();
      t_rise();
      t_stage();
      t_enable();
      t_restart();
      t_stop_fall();
      t_none();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule